// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block moves data between system memory and a card-side data FIFO by walking a chain of descriptors that software has placed in memory. Each descriptor names a memory address, a byte count and an attribute. The attribute says whether to move data, skip, or jump to another part of the table. Software loads a 64-bit descriptor pointer and then writes a command register. From then on the engine fetches, executes and chains descriptors with no further help. It stops when it completes a descriptor flagged as the last one, or when it meets a descriptor that is not marked valid.

Memory is reached through one request port. The port carries descriptor-word reads and 32-bit data beats, and completes a request in the cycle its ready input is high; read data is valid in that same cycle. The FIFO side has two streams with valid/ready handshakes: an outbound stream toward the card and an inbound stream from the card. A direction input selects which stream is used. An addressing-mode input selects either the 32-bit descriptor layout (8 bytes, low pointer half only) or the 64-bit layout (12 bytes, full pointer).

Top module: `sgDmaEngine`

## Requirements
- R1: After reset the engine is idle (busy, memReq, txValid and rxReady low, errFlag low). It issues no memory request until the command register (register offset 0x0C, any data) is written.
- R2: The pointer's low half is written at offset 0x58 and its high half at 0x5C. A write at offset 0x00 has no effect on the pointer. Pointer writes and command writes made while busy are ignored.
- R3: In 32-bit mode a descriptor is two words, read from the pointer and the pointer+4. In word 0, bit 0 is Valid, bit 1 is End, bit 2 is Int, bits 5:4 are the action and bits 31:16 are the byte length. Word 1 is the address. Only the low pointer half is used, memAddr[63:32] stays 0, and the next descriptor is fetched 8 bytes further on.
- R4: In 64-bit mode a descriptor is three words: word 0 as in R3, word 1 the address low half and word 2 the address high half. The full pointer is used and the next descriptor is fetched 12 bytes further on.
- R5: Action 2'b10 moves ceil(length/4) 32-bit beats at consecutive word addresses, starting at the descriptor address. A length of 0 means 65536 bytes (16384 beats).
- R6: With toCard high, each beat is read from memory and presented on the outbound stream, in address order.
- R7: With toCard low, each beat is taken from the inbound stream and written to memory, in order. No words outside the segment are written.
- R8: Action 2'b00 (and the unused code 2'b01) moves no data, and the engine proceeds to the next descriptor.
- R9: Action 2'b11 moves no data and loads the descriptor address into the pointer. The next descriptor is fetched from there.
- R10: When a descriptor with End set completes, xferDone pulses for one cycle and busy falls in the next cycle.
- R11: When a descriptor with Int set completes, dmaIrq pulses for one cycle.
- R12: A fetched descriptor with Valid = 0 stops the engine without moving data or pulsing xferDone. errIrq pulses once, and errFlag is set and held until the next start.
- R13: A low memRdy holds memReq, memWe, memAddr and memWData steady. A low txReady holds txValid and txData. No beat is lost or repeated under any stall pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| mode64 | input | 1 | 1 = 64-bit descriptor layout, 0 = 32-bit |
| toCard | input | 1 | 1 = memory to outbound stream, 0 = inbound stream to memory |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 64 | Byte address of the request |
| memWData | output | 32 | Write data |
| memRdy | input | 1 | Request completes this cycle |
| memRData | input | 32 | Read data, valid with memRdy |
| txValid | output | 1 | Outbound beat valid |
| txData | output | 32 | Outbound beat |
| txReady | input | 1 | Outbound beat accepted |
| rxValid | input | 1 | Inbound beat valid |
| rxData | input | 32 | Inbound beat |
| rxReady | output | 1 | Inbound beat accepted |
| busy | output | 1 | Engine is running |
| xferDone | output | 1 | One-cycle pulse when the End descriptor completes |
| dmaIrq | output | 1 | One-cycle pulse when an Int descriptor completes |
| errIrq | output | 1 | One-cycle pulse on an invalid descriptor |
| errFlag | output | 1 | Invalid descriptor seen since the last start |

## Verification
Single transfer descriptors are swept over byte lengths 1 through 9, which separates the rounding of partial words from whole-word lengths. A 0-length segment checks the 65536-byte case through a running sum of all beats. A mixed chain of transfer, skip and jump entries confirms that only transfer entries move data and that a jump redirects the fetch. A 64-bit chain with distinct upper address halves on the pointer and the segment shows the 12-byte step and the use of the high halves. Both directions run under memory, outbound and inbound stall patterns that repeat with different periods, so every handshake phase meets a stall. Invalid entries, stray register writes and writes made while busy show that these cases change nothing.

// File: rtl/sgDmaPkg.sv
package sgDmaPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_MOVE_A, ST_MOVE_B, ST_FINISH, ST_ERROR
  } dmaState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ptrLoLoad;
    logic ptrHiLoad;
    logic wordCap;
    logic segLoad;
    logic holdLoad;
    logic beatAdv;
    logic ptrStep;
    logic ptrLink;
  } dpStrobe_t;

  localparam logic [1:0] ACT_NOP  = 2'b00;
  localparam logic [1:0] ACT_XFER = 2'b10;
  localparam logic [1:0] ACT_LINK = 2'b11;

endpackage

// File: rtl/sgDmaCtrl.sv
module sgDmaCtrl
  import sgDmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdHit,
  input  logic       ptrLoHit,
  input  logic       ptrHiHit,
  input  logic       mode64,
  input  logic       toCard,
  input  logic       memRdy,
  input  logic       txReady,
  input  logic       rxValid,
  input  logic       descValid,
  input  logic       descEnd,
  input  logic       descInt,
  input  logic [1:0] descAct,
  input  logic       lastBeat,
  output dpStrobe_t  strobe,
  output logic [1:0] fetchIdx,
  output logic       dataPhase,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       rxReady,
  output logic       busy,
  output logic       xferDone,
  output logic       dmaIrq,
  output logic       errIrq,
  output logic       errFlag
);

  dmaState_e state, nxt;
  logic [1:0] lastIdx;

  assign lastIdx = mode64 ? 2'd2 : 2'd1;

  always_comb begin
    strobe           = '0;
    strobe.ptrLoLoad = ptrLoHit && (state == ST_IDLE);
    strobe.ptrHiLoad = ptrHiHit && (state == ST_IDLE);
    strobe.wordCap   = (state == ST_FETCH) && memRdy;
    strobe.segLoad   = (state == ST_DECODE) && descValid && (descAct == ACT_XFER);
    strobe.holdLoad  = (state == ST_MOVE_A) && (toCard ? memRdy : rxValid);
    strobe.beatAdv   = (state == ST_MOVE_B) && (toCard ? txReady : memRdy);
    strobe.ptrStep   = (state == ST_FINISH) && !descEnd && (descAct != ACT_LINK);
    strobe.ptrLink   = (state == ST_FINISH) && !descEnd && (descAct == ACT_LINK);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (cmdHit) nxt = ST_FETCH;
      ST_FETCH:  if (memRdy && fetchIdx == lastIdx) nxt = ST_DECODE;
      ST_DECODE: begin
        if (!descValid)              nxt = ST_ERROR;
        else if (descAct == ACT_XFER) nxt = ST_MOVE_A;
        else                          nxt = ST_FINISH;
      end
      ST_MOVE_A: if (strobe.holdLoad) nxt = ST_MOVE_B;
      ST_MOVE_B: if (strobe.beatAdv) nxt = lastBeat ? ST_FINISH : ST_MOVE_A;
      ST_FINISH: nxt = descEnd ? ST_IDLE : ST_FETCH;
      ST_ERROR:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchIdx <= '0;
      errFlag  <= 1'b0;
    end else begin
      state <= nxt;
      if (strobe.wordCap) fetchIdx <= (fetchIdx == lastIdx) ? 2'd0 : fetchIdx + 2'd1;
      if (state == ST_ERROR) errFlag <= 1'b1;
      else if (state == ST_IDLE && cmdHit) errFlag <= 1'b0;
    end
  end

  assign dataPhase = (state != ST_FETCH);
  assign memReq    = (state == ST_FETCH) || (state == ST_MOVE_A && toCard)
                     || (state == ST_MOVE_B && !toCard);
  assign memWe     = (state == ST_MOVE_B) && !toCard;
  assign txValid   = (state == ST_MOVE_B) && toCard;
  assign rxReady   = (state == ST_MOVE_A) && !toCard;
  assign busy      = (state != ST_IDLE);
  assign xferDone  = (state == ST_FINISH) && descEnd;
  assign dmaIrq    = (state == ST_FINISH) && descInt;
  assign errIrq    = (state == ST_ERROR);

  // R1
  idle_until_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdHit));

  // R10
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !busy);

  // R12
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> (!busy && errFlag));

endmodule

// File: rtl/sgDmaPath.sv
module sgDmaPath
  import sgDmaPkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        fetchIdx,
  input  logic              dataPhase,
  input  logic              mode64,
  input  logic              toCard,
  input  logic              memReq,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRData,
  input  logic [DATA_W-1:0] rxData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] beatData,
  output logic              descValid,
  output logic              descEnd,
  output logic              descInt,
  output logic [1:0]        descAct,
  output logic              lastBeat
);

  localparam int HALF_W  = ADDR_W / 2;
  localparam int BEAT_W  = LEN_W - 1;
  localparam int STEP32  = 2 * (DATA_W / 8);
  localparam int STEP64  = 3 * (DATA_W / 8);
  localparam int BEAT_B  = DATA_W / 8;

  logic [ADDR_W-1:0] ptrReg, ptrEff, descAddr, curAddr;
  logic [LEN_W-1:0]  descLen;
  logic [4:0]        descFlags;  // {act[1:0], int, end, valid}
  logic [BEAT_W-1:0] beatCnt, segBeats;
  logic [DATA_W-1:0] holdReg;
  logic [LEN_W:0]    lenFull, lenRound;

  assign ptrEff   = mode64 ? ptrReg : {{HALF_W{1'b0}}, ptrReg[HALF_W-1:0]};
  assign lenFull  = {(descLen == '0), descLen};
  assign lenRound = lenFull + (LEN_W+1)'(BEAT_B - 1);
  assign segBeats = lenRound[LEN_W:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg    <= '0;
      descAddr  <= '0;
      curAddr   <= '0;
      descLen   <= '0;
      descFlags <= '0;
      beatCnt   <= '0;
      holdReg   <= '0;
    end else begin
      if (strobe.ptrLoLoad) ptrReg[HALF_W-1:0]      <= regWrData;
      if (strobe.ptrHiLoad) ptrReg[ADDR_W-1:HALF_W] <= regWrData;
      if (strobe.wordCap) begin
        unique case (fetchIdx)
          2'd0: begin
            descLen   <= memRData[31:16];
            descFlags <= {memRData[5:4], memRData[2:0]};
          end
          2'd1: begin
            descAddr[HALF_W-1:0] <= memRData;
            if (!mode64) descAddr[ADDR_W-1:HALF_W] <= '0;
          end
          default: descAddr[ADDR_W-1:HALF_W] <= memRData;
        endcase
      end
      if (strobe.segLoad) begin
        curAddr <= descAddr;
        beatCnt <= segBeats;
      end
      if (strobe.holdLoad) holdReg <= toCard ? memRData : rxData;
      if (strobe.beatAdv) begin
        curAddr <= curAddr + ADDR_W'(BEAT_B);
        beatCnt <= beatCnt - BEAT_W'(1);
      end
      if (strobe.ptrStep) ptrReg <= ptrEff + ADDR_W'(mode64 ? STEP64 : STEP32);
      if (strobe.ptrLink) ptrReg <= descAddr;
    end
  end

  assign memAddr   = dataPhase ? curAddr : ptrEff + ADDR_W'({fetchIdx, 2'b00});
  assign beatData  = holdReg;
  assign descValid = descFlags[0];
  assign descEnd   = descFlags[1];
  assign descInt   = descFlags[2];
  assign descAct   = descFlags[4:3];
  assign lastBeat  = (beatCnt == BEAT_W'(1));

  // R5
  beat_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatAdv |-> (beatCnt != '0));

  // R3
  addr32_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !mode64) |-> (memAddr[ADDR_W-1:HALF_W] == '0));

endmodule

// File: rtl/sgDmaEngine.sv
module sgDmaEngine
  import sgDmaPkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          DATA_W     = 32,
  parameter int          LEN_W      = 16,
  parameter int          REG_AW     = 8,
  parameter logic [7:0]  PTR_LO_OFS = 8'h58,
  parameter logic [7:0]  PTR_HI_OFS = 8'h5C,
  parameter logic [7:0]  CMD_OFS    = 8'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              mode64,
  input  logic              toCard,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memRdy,
  input  logic [DATA_W-1:0] memRData,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              busy,
  output logic              xferDone,
  output logic              dmaIrq,
  output logic              errIrq,
  output logic              errFlag
);

  dpStrobe_t         strobe;
  logic [1:0]        fetchIdx, descAct;
  logic              dataPhase, descValid, descEnd, descInt, lastBeat;
  logic              cmdHit, ptrLoHit, ptrHiHit;
  logic [DATA_W-1:0] beatData;

  assign cmdHit   = regWrEn && (regAddr == REG_AW'(CMD_OFS));
  assign ptrLoHit = regWrEn && (regAddr == REG_AW'(PTR_LO_OFS));
  assign ptrHiHit = regWrEn && (regAddr == REG_AW'(PTR_HI_OFS));

  sgDmaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdHit(cmdHit), .ptrLoHit(ptrLoHit), .ptrHiHit(ptrHiHit),
    .mode64(mode64), .toCard(toCard), .memRdy(memRdy), .txReady(txReady),
    .rxValid(rxValid), .descValid(descValid), .descEnd(descEnd), .descInt(descInt),
    .descAct(descAct), .lastBeat(lastBeat), .strobe(strobe), .fetchIdx(fetchIdx),
    .dataPhase(dataPhase), .memReq(memReq), .memWe(memWe), .txValid(txValid),
    .rxReady(rxReady), .busy(busy), .xferDone(xferDone), .dmaIrq(dmaIrq),
    .errIrq(errIrq), .errFlag(errFlag)
  );

  sgDmaPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchIdx(fetchIdx), .dataPhase(dataPhase),
    .mode64(mode64), .toCard(toCard), .memReq(memReq), .regWrData(regWrData),
    .memRData(memRData), .rxData(rxData), .memAddr(memAddr), .beatData(beatData),
    .descValid(descValid), .descEnd(descEnd), .descInt(descInt), .descAct(descAct),
    .lastBeat(lastBeat)
  );

  assign memWData = beatData;
  assign txData   = beatData;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

endmodule

// File: tb/sgDmaEngine_test.sv
`timescale 1ns/1ps
module sgDmaEngine_test;

  localparam logic [7:0] PLO = 8'h58, PHI = 8'h5C, CMD = 8'h0C;

  logic        clk = 0, rstN = 0;
  logic        regWrEn = 0;
  logic [7:0]  regAddr = 0;
  logic [31:0] regWrData = 0;
  logic        mode64 = 0, toCard = 1;
  logic        memReq, memWe, memRdy = 0;
  logic [63:0] memAddr;
  logic [31:0] memWData, memRData, txData, rxData = 0;
  logic        txValid, txReady = 0, rxValid = 0, rxReady;
  logic        busy, xferDone, dmaIrq, errIrq, errFlag;

  logic [31:0] mem [0:1023];
  logic [31:0] txLog [0:63];
  int checks = 0, errors = 0, cyc = 0;
  int txCount, reqCnt, hi0, hi1, hi2, doneCnt, irqCnt, errCnt, rxIdx;
  logic [31:0] txSum;

  assign memRData = mem[memAddr[11:2]];

  sgDmaEngine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .mode64(mode64), .toCard(toCard), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memRdy(memRdy), .memRData(memRData), .txValid(txValid),
    .txData(txData), .txReady(txReady), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .busy(busy), .xferDone(xferDone), .dmaIrq(dmaIrq),
    .errIrq(errIrq), .errFlag(errFlag)
  );

  initial forever #2 clk = ~clk;

  // Stall patterns, memory model and stream monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      memRdy  = (cyc % 3) != 0;
      txReady = (cyc % 5) != 1;
      rxValid = (cyc % 4) != 2;
      rxData  = 32'h5A00_0000 + rxIdx;
      #1;
      if (rstN) begin
        if (memReq && memRdy) begin
          reqCnt++;
          if (memAddr[63:32] == 0) hi0++;
          if (memAddr[63:32] == 1) hi1++;
          if (memAddr[63:32] == 2) hi2++;
          if (memWe) mem[memAddr[11:2]] = memWData;
        end
        if (txValid && txReady) begin
          if (txCount < 64) txLog[txCount] = txData;
          txSum = txSum + txData;
          txCount++;
        end
        if (rxValid && rxReady) rxIdx++;
        if (xferDone) doneCnt++;
        if (dmaIrq) irqCnt++;
        if (errIrq) errCnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic initMem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + i;
  endtask

  task automatic clearCounts();
    txCount = 0; reqCnt = 0; hi0 = 0; hi1 = 0; hi2 = 0;
    doneCnt = 0; irqCnt = 0; errCnt = 0; rxIdx = 0; txSum = 0;
  endtask

  function automatic logic [31:0] attrWord(input bit v, input bit e, input bit irq,
                                           input logic [1:0] act, input logic [15:0] len);
    return {len, 10'b0, act, 1'b0, irq, e, v};
  endfunction

  task automatic putDesc32(input int at, input bit v, input bit e, input bit irq,
                           input logic [1:0] act, input logic [15:0] len, input logic [31:0] a);
    mem[at >> 2]       = attrWord(v, e, irq, act, len);
    mem[(at >> 2) + 1] = a;
  endtask

  task automatic putDesc64(input int at, input bit v, input bit e, input bit irq,
                           input logic [1:0] act, input logic [15:0] len, input logic [63:0] a);
    mem[at >> 2]       = attrWord(v, e, irq, act, len);
    mem[(at >> 2) + 1] = a[31:0];
    mem[(at >> 2) + 2] = a[63:32];
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runAt(input logic [31:0] lo, input logic [31:0] hi);
    regWrite(PLO, lo);
    regWrite(PHI, hi);
    clearCounts();
    regWrite(CMD, 32'h1);
    waitIdle();
  endtask

  initial begin
    int bad;
    logic [31:0] expSum;
    initMem();
    clearCounts();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state and no activity before the command
    chkEq("R1 busy after reset", busy, 0);
    chkEq("R1 memReq after reset", memReq, 0);
    chkEq("R1 txValid after reset", txValid, 0);
    chkEq("R1 errFlag after reset", errFlag, 0);
    putDesc32(32'h800, 1, 1, 0, 2'b10, 16'd8, 32'h100);
    regWrite(PLO, 32'h800);
    repeat (10) @(negedge clk);
    chkEq("R1 no request before command", reqCnt, 0);
    chkEq("R1 still idle before command", busy, 0);

    // R5 R6 R3 R10 R13: length sweep, 32-bit, to card
    for (int len = 1; len <= 9; len++) begin
      int base;
      base = 32'h40 + len * 32'h20;
      initMem();
      putDesc32(32'h800, 1, 1, 0, 2'b10, 16'(len), base);
      runAt(32'h800, 32'h0);
      chkEq($sformatf("R5 beats for len %0d", len), txCount, (len + 3) / 4);
      bad = 0;
      for (int k = 0; k < (len + 3) / 4; k++)
        if (txLog[k] !== mem[(base >> 2) + k]) bad++;
      chkEq($sformatf("R6 R13 data for len %0d", len), bad, 0);
      chkEq($sformatf("R10 done count len %0d", len), doneCnt, 1);
      chkEq($sformatf("R3 high half zero len %0d", len), hi0, reqCnt);
    end

    // R8 R9 R11 R2: mixed chain with stray register writes
    initMem();
    putDesc32(32'h800, 1, 0, 1, 2'b10, 16'd8, 32'h100);
    putDesc32(32'h808, 1, 0, 0, 2'b00, 16'd16, 32'h300);
    putDesc32(32'h810, 1, 0, 0, 2'b01, 16'd16, 32'h300);
    putDesc32(32'h818, 1, 0, 0, 2'b11, 16'd0, 32'h900);
    putDesc32(32'h900, 1, 1, 1, 2'b10, 16'd4, 32'h200);
    for (int i = 0; i < 8; i++) mem[(32'hC00 >> 2) + i] = 32'h0;
    regWrite(PLO, 32'h800);
    regWrite(PHI, 32'h0);
    regWrite(8'h00, 32'hC00);
    clearCounts();
    regWrite(CMD, 32'h1);
    repeat (2) @(negedge clk);
    regWrite(PLO, 32'hC00);
    regWrite(CMD, 32'h1);
    waitIdle();
    chkEq("R8 R9 beat count of chain", txCount, 3);
    chkEq("R6 chain beat 0", txLog[0], 32'hA500_0040);
    chkEq("R6 chain beat 1", txLog[1], 32'hA500_0041);
    chkEq("R9 beat after link", txLog[2], 32'hA500_0080);
    chkEq("R11 interrupt pulses", irqCnt, 2);
    chkEq("R2 one completion despite busy writes", doneCnt, 1);
    chkEq("R2 no error from ignored pointer", errCnt, 0);

    // R7: inbound to memory, 10 bytes -> 3 beats
    initMem();
    toCard = 0;
    putDesc32(32'h800, 1, 1, 0, 2'b10, 16'd10, 32'h300);
    runAt(32'h800, 32'h0);
    bad = 0;
    for (int k = 0; k < 3; k++)
      if (mem[(32'h300 >> 2) + k] !== 32'h5A00_0000 + k) bad++;
    chkEq("R7 written words", bad, 0);
    chkEq("R7 word after segment untouched", mem[(32'h300 >> 2) + 3], 32'hA500_00C3);
    chkEq("R7 word before segment untouched", mem[(32'h300 >> 2) - 1], 32'hA500_00BF);
    chkEq("R7 inbound beats taken", rxIdx, 3);
    toCard = 1;

    // R4: 64-bit layout, 12-byte step, upper halves
    initMem();
    mode64 = 1;
    putDesc64(32'h800, 1, 0, 0, 2'b10, 16'd8, {32'h2, 32'h180});
    putDesc64(32'h80C, 1, 1, 0, 2'b10, 16'd4, {32'h0, 32'h1C0});
    runAt(32'h800, 32'h1);
    chkEq("R4 beat count", txCount, 3);
    chkEq("R4 second descriptor data", txLog[2], 32'hA500_0070);
    chkEq("R4 fetches use pointer high half", hi1, 6);
    chkEq("R4 segment uses address high half", hi2, 2);
    chkEq("R4 low-only segment", hi0, 1);
    mode64 = 0;

    // R12: invalid descriptor
    initMem();
    putDesc32(32'h800, 0, 1, 1, 2'b10, 16'd8, 32'h100);
    runAt(32'h800, 32'h0);
    chkEq("R12 error pulse", errCnt, 1);
    chkEq("R12 error flag", errFlag, 1);
    chkEq("R12 no beats", txCount, 0);
    chkEq("R12 no done", doneCnt, 0);
    chkEq("R12 stopped", busy, 0);

    // R5: length 0 means 65536 bytes; flag clears on restart
    initMem();
    putDesc32(32'h800, 1, 1, 0, 2'b10, 16'd0, 32'h0);
    expSum = 0;
    for (int k = 0; k < 16384; k++) expSum = expSum + mem[k % 1024];
    runAt(32'h800, 32'h0);
    chkEq("R5 full-size beats", txCount, 16384);
    chkEq("R5 full-size data sum", txSum, expSum);
    chkEq("R12 flag cleared by new start", errFlag, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule